// File: doc/BRIEF.md
# Chip-Select Window Decoder

This block splits a 128 MB external bus window, based at 0x08000000, among four chip-select lines. Each chip select carries a configuration entry made of an enable bit and a 2-bit size code. The enabled chip selects get regions placed one after another from the window base, in chip-select order. Each incoming access is decoded to a one-hot chip-select vector. An access that no enabled region claims gets an error response instead.

A legality checker watches the configuration at all times. It allows only four layouts: 128/0/0/0, 64/64/0/0, 64/32/32/0 and 32/32/32/32 MB for chip selects 0 to 3. Any other layout raises a configuration error, and while that flag is high every access is refused. Configuration writes go through a narrow write port. A write that arrives while an access is being taken is held back, so region boundaries never move under a live access.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, chip select 0 is enabled with size code 10 and chip selects 1 to 3 are disabled with size code 00. config_error is low and rsp_valid is low, so every in-window address selects chip select 0.
- R2: A size code of 00 gives 32 MB, 01 gives 64 MB and 10 gives 128 MB. Code 11 on an enabled chip select raises config_error.
- R3: Enabled regions are packed from 0x08000000 upward in chip-select order. Each region starts at the base plus the sum of the sizes of the enabled chip selects with lower indices.
- R4: An enabled chip select whose size code is larger than that of the enabled chip select just below it raises config_error. For example, 32/64/32 is illegal.
- R5: config_error is raised when the enabled sizes add up to anything other than 128 MB, including the case where no chip select is enabled.
- R6: config_error is raised when an enabled chip select follows a disabled one, so enabled chip selects must form an unbroken run starting at chip select 0.
- R7: An access accepted while config_error is high produces rsp_cs of 0000 and rsp_err of 1.
- R8: An access presented with req_valid high at a clock edge produces rsp_valid high, with rsp_cs and rsp_err, during the following cycle. In a cycle that follows an edge without a request, rsp_valid, rsp_cs and rsp_err are all low. Back-to-back requests each get their own response.
- R9: An address below 0x08000000 or at or above 0x10000000 produces rsp_cs of 0000 and rsp_err of 1.
- R10: Under a legal configuration, an in-window address produces exactly one rsp_cs bit (bit i for chip select i) and rsp_err of 0.
- R11: Each configuration write updates one entry, chosen by cfg_sel.
  - A write at an edge where req_valid is low takes effect at that edge.
  - A write at an edge where req_valid is high is held and takes effect at the first later edge where req_valid is low.
  - A newer held write replaces an older one that has not yet taken effect.
- R12: The size code of a disabled chip select is ignored. A code of 11 or 10 on a disabled entry raises no config_error and does not change the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Index of the chip-select entry to write |
| cfg_active | input | 1 | Enable bit written into the entry |
| cfg_size | input | 2 | Size code written into the entry (00=32 MB, 01=64 MB, 10=128 MB, 11 reserved) |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Byte address of the access |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_cs | output | 4 | One-hot chip select of the access, bit i for chip select i |
| rsp_err | output | 1 | Decode error: no region claimed the access |
| config_error | output | 1 | Current configuration is not one of the legal layouts |

## Verification
Each legal layout is loaded and probed at the first and last byte of every region. A decoder that added offsets wrongly, or that counted disabled entries, would select a neighbour at one of those edges.

The bench loads the layout with a small region below a larger one, as well as a short total, a gap between enabled entries, and a reserved code. A checker that compared only totals, or that looked at disabled entries, would accept one of these or reject the layout with stale codes on disabled entries.

Addresses one byte outside each end of the window must be refused. A write issued during a run of requests must stay invisible until the bus goes idle, and a second held write must replace the first. A design that applied writes at once would switch chip select in the middle of that run. A design that queued both held writes would raise a reserved-code error.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;

   // One configuration entry per chip select
   typedef struct packed {
      logic       act;
      logic [1:0] size;
   } cs_cfg_t;

   localparam logic [1:0] SZ_32M  = 2'b00;
   localparam logic [1:0] SZ_64M  = 2'b01;
   localparam logic [1:0] SZ_128M = 2'b10;
   localparam logic [1:0] SZ_RSVD = 2'b11;

   // Largest legal size expressed in 32 MB units
   localparam int MAX_UNITS = 4;

   // Region size in 32 MB units; the reserved code yields zero
   function automatic logic [7:0] units_of(input logic [1:0] code);
      case (code)
         SZ_32M:  return 8'd1;
         SZ_64M:  return 8'd2;
         SZ_128M: return 8'd4;
         default: return 8'd0;
      endcase
   endfunction

endpackage

// File: rtl/csd_cfg_regs.sv
`timescale 1ns/1ps
module csd_cfg_regs
   import csd_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int SEL_W  = $clog2(NUM_CS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [SEL_W-1:0]       wr_sel_i,
   input  cs_cfg_t                wr_cfg_i,
   input  logic                   busy_i,
   output cs_cfg_t [NUM_CS-1:0]   cfg_o
);

   localparam cs_cfg_t CFG_RST0 = '{act: 1'b1, size: SZ_128M};
   localparam cs_cfg_t CFG_RSTN = '{act: 1'b0, size: SZ_32M};

   cs_cfg_t [NUM_CS-1:0] cfg_q;
   logic                 hold_v_q;
   logic [SEL_W-1:0]     hold_sel_q;
   cs_cfg_t              hold_cfg_q;

   // Writes land only on edges with no access being taken; a write during
   // an access waits in a single slot, newest wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CS; i++)
            cfg_q[i] <= (i == 0) ? CFG_RST0 : CFG_RSTN;
         hold_v_q   <= 1'b0;
         hold_sel_q <= '0;
         hold_cfg_q <= '0;
      end else if (busy_i) begin
         if (wr_en_i) begin
            hold_v_q   <= 1'b1;
            hold_sel_q <= wr_sel_i;
            hold_cfg_q <= wr_cfg_i;
         end
      end else begin
         if (hold_v_q) begin
            cfg_q[hold_sel_q] <= hold_cfg_q;
            hold_v_q          <= 1'b0;
         end
         if (wr_en_i)
            cfg_q[wr_sel_i] <= wr_cfg_i;
      end
   end

   assign cfg_o = cfg_q;

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(cfg_q)); // R11

   AST_HOLD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_v_q && !busy_i) |=> !hold_v_q); // R11

endmodule

// File: rtl/csd_cfg_check.sv
`timescale 1ns/1ps
module csd_cfg_check
   import csd_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int NUM_UNITS = 4,
   parameter int SUM_W     = 5
) (
   input  cs_cfg_t [NUM_CS-1:0]            cfg_i,
   output logic    [NUM_CS-1:0][SUM_W-1:0] base_o,
   output logic    [NUM_CS-1:0][SUM_W-1:0] size_o,
   output logic                            cfg_err_o
);

   logic [NUM_CS-1:0]          rsvd;
   logic [NUM_CS-1:0]          gap;
   logic [NUM_CS-1:0]          grow;
   logic [NUM_CS:0][SUM_W-1:0] run;

   assign run[0] = '0;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_ent
      assign size_o[i]  = cfg_i[i].act ? SUM_W'(units_of(cfg_i[i].size)) : '0;
      assign base_o[i]  = run[i];
      assign run[i+1]   = run[i] + size_o[i];
      assign rsvd[i]    = cfg_i[i].act && (cfg_i[i].size == SZ_RSVD);
      if (i == 0) begin : g_first
         assign gap[i]  = 1'b0;
         assign grow[i] = 1'b0;
      end else begin : g_rest
         // an enabled entry after a disabled one breaks the packed run
         assign gap[i]  = cfg_i[i].act && !cfg_i[i-1].act;
         // a region larger than its predecessor breaks the ordering
         assign grow[i] = cfg_i[i].act && cfg_i[i-1].act &&
                          (cfg_i[i].size > cfg_i[i-1].size);
      end
   end

   assign cfg_err_o = (|rsvd) || (|gap) || (|grow) ||
                      (run[NUM_CS] != SUM_W'(NUM_UNITS));

endmodule

// File: rtl/csd_addr_match.sv
`timescale 1ns/1ps
module csd_addr_match #(
   parameter int                NUM_CS    = 4,
   parameter int                ADDR_W    = 32,
   parameter int                UNIT_LOG2 = 25,
   parameter int                NUM_UNITS = 4,
   parameter int                SUM_W     = 5,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0800_0000
) (
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [NUM_CS-1:0][SUM_W-1:0] base_i,
   input  logic [NUM_CS-1:0][SUM_W-1:0] size_i,
   input  logic                         block_i,
   output logic [NUM_CS-1:0]            hit_o,
   output logic                         in_win_o
);

   localparam int                IDX_W     = $clog2(NUM_UNITS);
   localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(NUM_UNITS) << UNIT_LOG2;

   logic [ADDR_W-1:0] off;
   logic [SUM_W-1:0]  unit;

   assign off      = addr_i - WIN_BASE;
   assign in_win_o = (off < WIN_BYTES);
   assign unit     = SUM_W'(off[UNIT_LOG2 +: IDX_W]);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
      logic [SUM_W:0] lim;
      assign lim      = {1'b0, base_i[i]} + {1'b0, size_i[i]};
      assign hit_o[i] = in_win_o && !block_i && (size_i[i] != '0) &&
                        (unit >= base_i[i]) && ({1'b0, unit} < lim);
   end

endmodule

// File: rtl/cs_window_decoder.sv
`timescale 1ns/1ps
module cs_window_decoder
   import csd_pkg::*;
#(
   parameter int                NUM_CS    = 4,
   parameter int                ADDR_W    = 32,
   parameter int                UNIT_LOG2 = 25,
   parameter int                NUM_UNITS = 4,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0800_0000,
   localparam int               SEL_W     = $clog2(NUM_CS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic              cfg_active,
   input  logic [1:0]        cfg_size,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [NUM_CS-1:0] rsp_cs,
   output logic              rsp_err,
   output logic              config_error
);

   localparam int SUM_W = $clog2(NUM_CS * MAX_UNITS + 1);

   // elaboration-time parameter checks
   if (NUM_CS < 2) begin : g_bad_cs
      $error("NUM_CS must be at least 2");
   end
   if (NUM_UNITS < 2 || (NUM_UNITS & (NUM_UNITS - 1)) != 0) begin : g_bad_units
      $error("NUM_UNITS must be a power of two, at least 2");
   end
   if (UNIT_LOG2 + $clog2(NUM_UNITS) >= ADDR_W) begin : g_bad_win
      $error("window does not fit in the address width");
   end
   if ((WIN_BASE & ((ADDR_W'(NUM_UNITS) << UNIT_LOG2) - 1'b1)) != '0) begin : g_bad_base
      $error("WIN_BASE must be aligned to the window size");
   end

   cs_cfg_t [NUM_CS-1:0]            cfg;
   cs_cfg_t                         wr_cfg;
   logic    [NUM_CS-1:0][SUM_W-1:0] reg_base;
   logic    [NUM_CS-1:0][SUM_W-1:0] reg_size;
   logic                            cfg_err;
   logic    [NUM_CS-1:0]            hit;
   logic                            in_win;

   logic              rsp_valid_q;
   logic [NUM_CS-1:0] rsp_cs_q;
   logic              rsp_err_q;

   assign wr_cfg = '{act: cfg_active, size: cfg_size};

   csd_cfg_regs #(
      .NUM_CS (NUM_CS),
      .SEL_W  (SEL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (cfg_we),
      .wr_sel_i (cfg_sel),
      .wr_cfg_i (wr_cfg),
      .busy_i   (req_valid),
      .cfg_o    (cfg)
   );

   csd_cfg_check #(
      .NUM_CS    (NUM_CS),
      .NUM_UNITS (NUM_UNITS),
      .SUM_W     (SUM_W)
   ) u_check (
      .cfg_i     (cfg),
      .base_o    (reg_base),
      .size_o    (reg_size),
      .cfg_err_o (cfg_err)
   );

   csd_addr_match #(
      .NUM_CS    (NUM_CS),
      .ADDR_W    (ADDR_W),
      .UNIT_LOG2 (UNIT_LOG2),
      .NUM_UNITS (NUM_UNITS),
      .SUM_W     (SUM_W),
      .WIN_BASE  (WIN_BASE)
   ) u_match (
      .addr_i   (req_addr),
      .base_i   (reg_base),
      .size_i   (reg_size),
      .block_i  (cfg_err),
      .hit_o    (hit),
      .in_win_o (in_win)
   );

   // one register stage between request and response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_cs_q    <= '0;
         rsp_err_q   <= 1'b0;
      end else begin
         rsp_valid_q <= req_valid;
         rsp_cs_q    <= req_valid ? hit : '0;
         rsp_err_q   <= req_valid && (hit == '0);
      end
   end

   assign rsp_valid    = rsp_valid_q;
   assign rsp_cs       = rsp_cs_q;
   assign rsp_err      = rsp_err_q;
   assign config_error = cfg_err;

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_cs == '0 && !rsp_err)); // R8

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0(rsp_cs)); // R10

   AST_CFGERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(config_error)) |-> (rsp_cs == '0 && rsp_err)); // R7

   AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(in_win)) |-> rsp_err); // R9

   AST_LEGAL_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(in_win) && !$past(config_error)) |-> !rsp_err); // R10

endmodule

// File: tb/sim_cs_window_decoder.sv
`timescale 1ns/1ps
module sim_cs_window_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_active = 1'b0;
   logic [1:0]  cfg_size = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid;
   logic [3:0]  rsp_cs;
   logic        rsp_err;
   logic        config_error;

   int n_vec  = 0;
   int n_fail = 0;

   // model state of the configuration, as the requirements describe it
   int b_act [4];
   int b_sz  [4];

   always #10 clk = ~clk;

   cs_window_decoder u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_sel      (cfg_sel),
      .cfg_active   (cfg_active),
      .cfg_size     (cfg_size),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .rsp_valid    (rsp_valid),
      .rsp_cs       (rsp_cs),
      .rsp_err      (rsp_err),
      .config_error (config_error)
   );

   function automatic int mb_of(input int code);
      return (code == 0) ? 32 : (code == 1) ? 64 : (code == 2) ? 128 : -1;
   endfunction

   function automatic int eff_mb(input int i);
      return b_act[i] != 0 ? mb_of(b_sz[i]) : 0;
   endfunction

   // legal iff the layout is one of the four listed ones
   function automatic bit legal_now();
      int m0 = eff_mb(0), m1 = eff_mb(1), m2 = eff_mb(2), m3 = eff_mb(3);
      return (m0 == 128 && m1 == 0  && m2 == 0  && m3 == 0)  ||
             (m0 == 64  && m1 == 64 && m2 == 0  && m3 == 0)  ||
             (m0 == 64  && m1 == 32 && m2 == 32 && m3 == 0)  ||
             (m0 == 32  && m1 == 32 && m2 == 32 && m3 == 32);
   endfunction

   task automatic check_bits(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_rsp(input logic [31:0] a, input string req);
      logic [3:0] exp_cs = '0;
      logic       exp_err;
      int         start = 0;
      bit         inw = (a >= 32'h0800_0000) && (a < 32'h1000_0000);
      if (legal_now() && inw) begin
         int off = int'((a - 32'h0800_0000) >> 20);
         for (int i = 0; i < 4; i++) begin
            int m = eff_mb(i);
            if (m > 0 && off >= start && off < start + m) exp_cs[i] = 1'b1;
            if (m > 0) start += m;
         end
      end
      exp_err = (exp_cs == '0);
      check_bits(req, {2'b0, rsp_valid, rsp_cs, rsp_err}, {2'b0, 1'b1, exp_cs, exp_err});
   endtask

   task automatic chk_cfgerr(input string req);
      check_bits(req, {7'b0, config_error}, {7'b0, !legal_now()});
   endtask

   task automatic wr(input int sel, input int act, input int code);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_active = 1'(act); cfg_size = 2'(code);
      @(negedge clk);
      cfg_we = 1'b0;
      b_act[sel] = act; b_sz[sel] = code;
   endtask

   task automatic set_cfg(input int a0, s0, a1, s1, a2, s2, a3, s3);
      wr(0, a0, s0); wr(1, a1, s1); wr(2, a2, s2); wr(3, a3, s3);
   endtask

   task automatic access(input logic [31:0] a, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk_rsp(a, req);
   endtask

   task automatic t_reset();
      check_bits("R1 rsp_valid after reset", {7'b0, rsp_valid}, 8'h00);
      chk_cfgerr("R1 config_error after reset");
      access(32'h0800_0000, "R1 default decode base");
      access(32'h0FFF_FFFF, "R1 default decode top");
      access(32'h0C00_0000, "R1 default decode middle");
   endtask

   task automatic probe_regions(input string req);
      int start = 0;
      for (int i = 0; i < 4; i++) begin
         int m = eff_mb(i);
         if (m > 0) begin
            access(32'h0800_0000 + 32'(start) * 32'h0010_0000, req);
            access(32'h0800_0000 + 32'(start + m) * 32'h0010_0000 - 1, req);
            start += m;
         end
      end
   endtask

   task automatic t_legal();
      set_cfg(1, 1, 1, 1, 0, 0, 0, 0);
      chk_cfgerr("R4 64/64 legal");
      probe_regions("R3 R2 R10 64/64 regions");
      set_cfg(1, 1, 1, 0, 1, 0, 0, 0);
      chk_cfgerr("R4 64/32/32 legal");
      probe_regions("R3 R2 R10 64/32/32 regions");
      set_cfg(1, 0, 1, 0, 1, 0, 1, 0);
      chk_cfgerr("R5 32x4 legal");
      probe_regions("R3 R10 32x4 regions");
      set_cfg(1, 2, 0, 0, 0, 0, 0, 0);
      chk_cfgerr("R1 128 legal");
      probe_regions("R3 R2 128 region");
   endtask

   task automatic t_pipeline();
      set_cfg(1, 0, 1, 0, 1, 0, 1, 0);
      @(negedge clk); req_valid = 1'b1; req_addr = 32'h0E00_0010;
      @(negedge clk); chk_rsp(32'h0E00_0010, "R8 back-to-back first");
      req_addr = 32'h0800_0000;
      @(negedge clk); chk_rsp(32'h0800_0000, "R8 back-to-back second");
      req_addr = 32'h0BFF_FFFF;
      @(negedge clk); chk_rsp(32'h0BFF_FFFF, "R8 back-to-back third");
      req_valid = 1'b0;
      @(negedge clk);
      check_bits("R8 idle after burst", {5'b0, rsp_valid, 1'b0, rsp_err}, 8'h00);
      check_bits("R8 idle cs", {4'b0, rsp_cs}, 8'h00);
   endtask

   task automatic t_window();
      access(32'h07FF_FFFF, "R9 one below window");
      access(32'h1000_0000, "R9 one above window");
      access(32'h0000_0000, "R9 address zero");
      access(32'hFFFF_FFFF, "R9 address max");
   endtask

   task automatic t_illegal();
      set_cfg(1, 3, 0, 0, 0, 0, 0, 0);
      chk_cfgerr("R2 reserved code on enabled entry");
      access(32'h0800_0000, "R7 decode blocked by reserved code");
      set_cfg(1, 0, 1, 1, 1, 0, 0, 0);
      chk_cfgerr("R4 32/64/32 growing order");
      access(32'h0A00_0000, "R7 decode blocked by order error");
      set_cfg(1, 1, 1, 0, 0, 0, 0, 0);
      chk_cfgerr("R5 total 96 MB");
      set_cfg(1, 0, 1, 0, 1, 0, 0, 0);
      chk_cfgerr("R5 total 96 MB three regions");
      set_cfg(0, 2, 0, 0, 0, 0, 0, 0);
      chk_cfgerr("R5 nothing enabled");
      access(32'h0900_0000, "R7 nothing enabled");
      set_cfg(1, 1, 0, 0, 1, 1, 0, 0);
      chk_cfgerr("R6 gap between enabled entries");
      access(32'h0C00_0000, "R7 decode blocked by gap");
   endtask

   task automatic t_inactive();
      set_cfg(1, 1, 1, 1, 0, 3, 0, 2);
      chk_cfgerr("R12 codes on disabled entries ignored");
      access(32'h0C00_0000, "R12 decode with junk disabled codes");
      access(32'h0E00_0000, "R12 upper region still CS1");
   endtask

   task automatic t_defer();
      set_cfg(1, 1, 1, 1, 0, 0, 0, 0);
      // write during a request run must wait
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0C00_0000;
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_active = 1'b1; cfg_size = 2'b00;
      @(negedge clk);
      cfg_we = 1'b0;
      chk_rsp(32'h0C00_0000, "R11 old layout during held write");
      chk_cfgerr("R11 held write not yet visible");
      req_addr = 32'h0A00_0000;
      @(negedge clk);
      chk_rsp(32'h0A00_0000, "R11 old layout second access");
      chk_cfgerr("R11 still held while busy");
      req_valid = 1'b0;
      @(negedge clk);
      b_sz[0] = 0;
      chk_cfgerr("R11 held write applied after idle");
      wr(0, 1, 1);
      chk_cfgerr("R11 restored legal layout");
      // newer held write replaces older one
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0800_0000;
      cfg_we = 1'b1; cfg_sel = 2'd1; cfg_active = 1'b1; cfg_size = 2'b11;
      @(negedge clk);
      chk_rsp(32'h0800_0000, "R11 access during first held write");
      cfg_sel = 2'd0; cfg_active = 1'b1; cfg_size = 2'b01;
      req_addr = 32'h0E00_0000;
      @(negedge clk);
      cfg_we = 1'b0;
      chk_rsp(32'h0E00_0000, "R11 access during second held write");
      req_valid = 1'b0;
      @(negedge clk);
      chk_cfgerr("R11 older held write replaced");
      access(32'h0C00_0000, "R11 CS1 unchanged by dropped write");
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin b_act[i] = 0; b_sz[i] = 0; end
      b_act[0] = 1; b_sz[0] = 2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_legal();
      t_pipeline();
      t_window();
      t_illegal();
      t_inactive();
      t_defer();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule